// File: doc/BRIEF.md
# SPI Master with Transmit and Receive Status Flags

This block is an SPI master built from a byte-oriented serial engine. Software writes a byte into a one-entry transmit holding register; as soon as the shifter is idle and transmission is enabled, the byte moves into an 8-bit shift register. It then goes out on the serial data output, most significant bit first, while the serial data input is sampled into a receive shift register. At the end of each frame the received byte lands in a one-entry receive holding register.

Three flags report progress: receive done, transmit done and transmit buffer empty. Each flag can raise an interrupt request when its own enable bit and a global interrupt enable input are both set. A small register bus reaches the data, status, control and baud-divisor registers. The serial clock idles low and runs at the system clock divided by 2*(divisor+1).

Top module: `spim_usart`

## Requirements
- R1: After reset the status register (address 1) reads 0x20, with only the buffer-empty bit 5 set. The control and data registers read 0x00, the serial clock is low and all three interrupt requests are low.
- R2: A write to the data register (address 0) fills the transmit buffer and clears status bit 5. If the shifter is idle and transmission is enabled, the byte moves to the shifter on the next clock and bit 5 sets again.
- R3: Frames use SPI mode 0 and shift the most significant bit first. The clock idles low, output data changes only on falling clock edges and input data is sampled on rising edges. Each clock half-period lasts divisor+1 system cycles, where the divisor is the register at address 3.
- R4: At the end of a frame with the receiver enabled, the received byte goes into the receive buffer and status bit 7 sets. A read of the data register returns that byte and clears bit 7.
- R5: Status bit 6 (transmit done) sets when a frame finishes with the transmit buffer empty. It does not set when another byte is already waiting.
- R6: Status bit 6 clears when a 1 is written to bit 6 of the status register, or when the transmit-done acknowledge input is high for a cycle. Writing 0 to bit 6 leaves it unchanged.
- R7: While the receiver enable (control bit 4) is 0, the receive buffer is flushed to 0x00 and status bit 7 stays 0. Frames completed in that state are discarded.
- R8: Each interrupt request is registered one cycle after its flag, its enable and the global enable input are all 1. The enables are control bit 7 for receive done, bit 6 for transmit done and bit 5 for buffer empty.
- R9: Control bits 7..3 read back as written and bits 2..0 read as 0. Status bits 4..0 read as 0. Read data appears on the clock after the read strobe.
- R10: A transfer starts only while the transmitter enable (control bit 3) is 1. Until then a written byte waits in the buffer and the serial clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control, 3 divisor |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| glb_irq_en | input | 1 | Global interrupt enable |
| tx_done_ack | input | 1 | Acknowledge of the transmit-done interrupt |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq_rx_done | output | 1 | Receive-done interrupt request |
| irq_tx_done | output | 1 | Transmit-done interrupt request |
| irq_tx_empty | output | 1 | Transmit-buffer-empty interrupt request |

## Verification
The assertions check, on every cycle, that the serial clock is low whenever the shifter is idle and that output data never moves while the clock is high. They also check that a data write always leaves the buffer full on the next cycle, that a disabled receiver holds the receive flag low, that the done flags rise only on a frame end, and that interrupts need the global enable. Only the bench scenarios can show the end-to-end behaviour: the byte order seen by an external slave, the exact half-period length, that back-to-back frames raise transmit done only once, and the correct priority of the flag clear paths. A behavioural model compares the clock, data and interrupt outputs against the design on every cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CTRL = 2'd2,
    A_BAUD = 2'd3
  } spim_addr_e;

  // status bit positions
  localparam int S_RXDONE = 7;
  localparam int S_TXDONE = 6;
  localparam int S_EMPTY  = 5;
  // control bit positions
  localparam int C_IE_RX  = 7;
  localparam int C_IE_TX  = 6;
  localparam int C_IE_EMP = 5;
  localparam int C_RX_EN  = 4;
  localparam int C_TX_EN  = 3;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == div);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               tick,
  input  logic               miso,
  output logic               busy,
  output logic               sck,
  output logic               mosi,
  output logic               done,
  output logic [FRAME_W-1:0] rx_byte
);
  localparam int CW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] tx_sh_q, rx_sh_q;
  logic [CW-1:0]      bit_q;
  logic               busy_q, sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
    end else if (start && !busy_q) begin
      tx_sh_q <= tx_byte;
      bit_q   <= '0;
      busy_q  <= 1'b1;
      sck_q   <= 1'b0;
    end else if (busy_q && tick) begin
      if (!sck_q) begin
        sck_q   <= 1'b1;                           // rising edge: sample
        rx_sh_q <= {rx_sh_q[FRAME_W-2:0], miso};
      end else begin
        sck_q <= 1'b0;                             // falling edge: advance
        if (bit_q == LAST) begin
          busy_q <= 1'b0;
        end else begin
          bit_q   <= bit_q + 1'b1;
          tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = busy_q & tx_sh_q[FRAME_W-1];
  assign done    = busy_q && tick && sck_q && (bit_q == LAST);
  assign rx_byte = rx_sh_q;

  // R3: clock idles low
  a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sck_q);
  // R3: data out only changes while the clock is low
  a_r3_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
    sck_q |-> $stable(mosi));
endmodule

// File: rtl/spim_flags.sv
module spim_flags
  import spim_pkg::*;
#(
  parameter logic [REG_W-1:0] DIV_RESET = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             gie,
  input  logic             tx_ack,
  input  logic             busy,
  input  logic             done,
  input  logic [REG_W-1:0] rx_byte,
  output logic             start,
  output logic [REG_W-1:0] tx_byte,
  output logic [REG_W-1:0] div,
  output logic             irq_rx,
  output logic             irq_tx,
  output logic             irq_emp
);
  spim_addr_e sel;
  assign sel = spim_addr_e'(addr);

  logic [REG_W-1:0] txbuf_q, rxbuf_q, div_q, rdata_q;
  logic [7:3]       ctrl_q;
  logic             txfull_q, rxdone_q, txdone_q;
  logic             irq_rx_q, irq_tx_q, irq_emp_q;
  logic             wr_data, wr_stat, wr_ctrl, wr_baud, rd_data;
  logic [REG_W-1:0] stat_w, ctrl_w;

  assign wr_data = wr && (sel == A_DATA);
  assign wr_stat = wr && (sel == A_STAT);
  assign wr_ctrl = wr && (sel == A_CTRL);
  assign wr_baud = wr && (sel == A_BAUD);
  assign rd_data = rd && (sel == A_DATA);

  assign start = !busy && txfull_q && ctrl_q[C_TX_EN];

  always_comb begin
    stat_w = '0;
    stat_w[S_RXDONE] = rxdone_q;
    stat_w[S_TXDONE] = txdone_q;
    stat_w[S_EMPTY]  = !txfull_q;
    ctrl_w = {ctrl_q, 3'b000};
  end

  // transmit buffer: a write wins over the hand-off in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      txbuf_q  <= '0;
      txfull_q <= 1'b0;
    end else begin
      if (wr_data) begin
        txbuf_q  <= wdata;
        txfull_q <= 1'b1;
      end else if (start) begin
        txfull_q <= 1'b0;
      end
    end
  end

  // receive buffer: flush, then frame end, then read clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rxbuf_q  <= '0;
      rxdone_q <= 1'b0;
    end else if (!ctrl_q[C_RX_EN]) begin
      rxbuf_q  <= '0;
      rxdone_q <= 1'b0;
    end else if (done) begin
      rxbuf_q  <= rx_byte;
      rxdone_q <= 1'b1;
    end else if (rd_data) begin
      rxdone_q <= 1'b0;
    end
  end

  // transmit done: set has priority over both clear paths
  always_ff @(posedge clk) begin
    if (rst) txdone_q <= 1'b0;
    else if (done && !txfull_q) txdone_q <= 1'b1;
    else if ((wr_stat && wdata[S_TXDONE]) || tx_ack) txdone_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= DIV_RESET;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[7:3];
      if (wr_baud) div_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      case (sel)
        A_DATA:  rdata_q <= rxbuf_q;
        A_STAT:  rdata_q <= stat_w;
        A_CTRL:  rdata_q <= ctrl_w;
        default: rdata_q <= div_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx_q  <= 1'b0;
      irq_tx_q  <= 1'b0;
      irq_emp_q <= 1'b0;
    end else begin
      irq_rx_q  <= gie && ctrl_q[C_IE_RX]  && rxdone_q;
      irq_tx_q  <= gie && ctrl_q[C_IE_TX]  && txdone_q;
      irq_emp_q <= gie && ctrl_q[C_IE_EMP] && !txfull_q;
    end
  end

  assign rdata   = rdata_q;
  assign tx_byte = txbuf_q;
  assign div     = div_q;
  assign irq_rx  = irq_rx_q;
  assign irq_tx  = irq_tx_q;
  assign irq_emp = irq_emp_q;

  // R2: a data write always leaves the buffer occupied
  a_r2_write_fills_buffer: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> txfull_q);
  // R7: disabled receiver flushes the receive flag
  a_r7_rx_flush: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[C_RX_EN] |=> !rxdone_q);
  // R5: transmit done only rises on a frame end with nothing waiting
  a_r5_txdone_source: assert property (@(posedge clk) disable iff (rst)
    $rose(txdone_q) |-> $past(done && !txfull_q));
  // R4: receive done only rises on a frame end
  a_r4_rxdone_source: assert property (@(posedge clk) disable iff (rst)
    $rose(rxdone_q) |-> $past(done));
  // R8: no interrupt request without the global enable
  a_r8_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
    (irq_rx_q || irq_tx_q || irq_emp_q) |-> $past(gie));
endmodule

// File: rtl/spim_usart.sv
module spim_usart
  import spim_pkg::*;
#(
  parameter logic [REG_W-1:0] DIV_RESET = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             glb_irq_en,
  input  logic             tx_done_ack,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             irq_rx_done,
  output logic             irq_tx_done,
  output logic             irq_tx_empty
);
  logic             busy, done, start, tick;
  logic [REG_W-1:0] rx_byte, tx_byte, div;

  spim_flags #(.DIV_RESET(DIV_RESET)) u_flags (
    .clk(clk), .rst(rst),
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .gie(glb_irq_en), .tx_ack(tx_done_ack),
    .busy(busy), .done(done), .rx_byte(rx_byte),
    .start(start), .tx_byte(tx_byte), .div(div),
    .irq_rx(irq_rx_done), .irq_tx(irq_tx_done), .irq_emp(irq_tx_empty)
  );

  spim_baud #(.DIV_W(REG_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .div(div), .tick(tick)
  );

  spim_shifter #(.FRAME_W(REG_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte), .tick(tick),
    .miso(spi_miso), .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
    .done(done), .rx_byte(rx_byte)
  );
endmodule

// File: tb/sim_spim_usart.sv
`timescale 1ns/1ps
module sim_spim_usart;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       glb_irq_en = 1'b0, tx_done_ack = 1'b0;
  logic       spi_sck, spi_mosi, spi_miso;
  logic       irq_rx_done, irq_tx_done, irq_tx_empty;

  always #4 clk = ~clk;

  spim_usart u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glb_irq_en(glb_irq_en),
    .tx_done_ack(tx_done_ack), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .irq_rx_done(irq_rx_done), .irq_tx_done(irq_tx_done),
    .irq_tx_empty(irq_tx_empty)
  );

  // external slave: shifts out on falling clock, captures on rising clock
  logic [7:0] slv_pat = 8'h00;
  logic [7:0] slv_in  = 8'h00;
  logic [2:0] fall_idx = 3'd0;
  int         hi_cnt = 0, txirq_rises = 0;
  assign spi_miso = slv_pat[3'd7 - fall_idx];
  always @(negedge spi_sck) fall_idx <= fall_idx + 3'd1;
  always @(posedge spi_sck) slv_in <= {slv_in[6:0], spi_mosi};
  always @(posedge clk) if (spi_sck) hi_cnt <= hi_cnt + 1;
  always @(posedge irq_tx_done) txirq_rises <= txirq_rises + 1;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_full, m_busy, m_sck, m_rxd, m_txd, m_irx, m_itx, m_iemp;
  bit [7:0] m_tx, m_sh, m_rs, m_rx, m_ctrl, m_div, m_rdata;
  int       m_half, m_bit;

  always @(posedge clk) begin
    bit o_full, o_rxd, o_txd, fin, go;
    bit [7:0] o_ctrl;
    if (rst) begin
      m_full = 0; m_busy = 0; m_sck = 0; m_rxd = 0; m_txd = 0;
      m_irx = 0; m_itx = 0; m_iemp = 0;
      m_tx = 0; m_sh = 0; m_rs = 0; m_rx = 0; m_ctrl = 0; m_div = 0; m_rdata = 0;
      m_half = 0; m_bit = 0;
    end else begin
      o_full = m_full; o_rxd = m_rxd; o_txd = m_txd; o_ctrl = m_ctrl;
      fin = 0;
      go  = !m_busy && m_full && m_ctrl[3];
      m_irx  = glb_irq_en && o_ctrl[7] && o_rxd;
      m_itx  = glb_irq_en && o_ctrl[6] && o_txd;
      m_iemp = glb_irq_en && o_ctrl[5] && !o_full;
      if (bus_rd)
        case (bus_addr)
          2'd0: m_rdata = m_rx;
          2'd1: m_rdata = {o_rxd, o_txd, !o_full, 5'b0};
          2'd2: m_rdata = o_ctrl;
          default: m_rdata = m_div;
        endcase
      if (m_busy) begin
        if (m_half == int'(m_div)) begin
          m_half = 0;
          if (!m_sck) begin
            m_sck = 1; m_rs = {m_rs[6:0], spi_miso};
          end else begin
            m_sck = 0;
            if (m_bit == 7) begin m_busy = 0; fin = 1; end
            else begin m_bit++; m_sh = m_sh << 1; end
          end
        end else m_half++;
      end else if (go) begin
        m_busy = 1; m_sh = m_tx; m_sck = 0; m_half = 0; m_bit = 0; m_full = 0;
      end
      if (!o_ctrl[4]) begin m_rxd = 0; m_rx = 0; end
      else if (fin) begin m_rx = m_rs; m_rxd = 1; end
      else if (bus_rd && bus_addr == 2'd0) m_rxd = 0;
      if (fin && !o_full) m_txd = 1;
      else if ((bus_wr && bus_addr == 2'd1 && bus_wdata[6]) || tx_done_ack) m_txd = 0;
      if (bus_wr)
        case (bus_addr)
          2'd0: begin m_tx = bus_wdata; m_full = 1; end
          2'd2: m_ctrl = bus_wdata & 8'hF8;
          2'd3: m_div = bus_wdata;
          default: ;
        endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 sck", {7'b0, spi_sck}, {7'b0, m_sck});
      chk("R3 mosi", {7'b0, spi_mosi}, {7'b0, m_busy & m_sh[7]});
      chk("R9 rdata", bus_rdata, m_rdata);
      chk("R8 irq_rx", {7'b0, irq_rx_done}, {7'b0, m_irx});
      chk("R8 irq_tx", {7'b0, irq_tx_done}, {7'b0, m_itx});
      chk("R8 irq_empty", {7'b0, irq_tx_empty}, {7'b0, m_iemp});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] pat);
    slv_pat = pat;
    wr(2'd0, tx);
    idle(40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int h0, r0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(2'd1, d); chk("R1 status after reset", d, 8'h20);
    rd(2'd2, d); chk("R1 control after reset", d, 8'h00);
    rd(2'd0, d); chk("R1 data after reset", d, 8'h00);
    chk("R1 outputs idle", {4'b0, spi_sck, irq_rx_done, irq_tx_done, irq_tx_empty}, 8'h00);

    // R9 register readback, R3 divisor
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R9 control readback", d, 8'hF8);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h01); rd(2'd3, d); chk("R3 divisor readback", d, 8'h01);

    // R10 transmitter disabled: byte waits
    wr(2'd2, 8'h10);
    h0 = hi_cnt;
    slv_pat = 8'h3C;
    wr(2'd0, 8'hA5);
    idle(40);
    rd(2'd1, d); chk("R10 byte waits, status", d, 8'h00);
    chk("R10 no clock while disabled", 8'(hi_cnt - h0), 8'h00);

    // R3/R4/R5 enable and run
    h0 = hi_cnt;
    wr(2'd2, 8'h18);
    idle(40);
    chk("R3 slave received MSB first", slv_in, 8'hA5);
    chk("R3 clock high cycles per frame", 8'(hi_cnt - h0), 8'd16);
    rd(2'd1, d); chk("R4 R5 status after frame", d, 8'hE0);
    rd(2'd0, d); chk("R4 received byte", d, 8'h3C);
    rd(2'd1, d); chk("R4 read clears rx flag", d, 8'h60);

    // R6 clear paths
    wr(2'd1, 8'h00); rd(2'd1, d); chk("R6 write zero keeps flag", d, 8'h60);
    wr(2'd1, 8'h40); rd(2'd1, d); chk("R6 write one clears flag", d, 8'h20);
    xfer(8'h5A, 8'h81);
    tx_done_ack = 1'b1; idle(1); tx_done_ack = 1'b0;
    rd(2'd1, d); chk("R6 acknowledge clears flag", d, 8'hA0);
    rd(2'd0, d); chk("R4 second byte", d, 8'h81);

    // R2 buffer empty timing
    wr(2'd0, 8'hC3);
    rd(2'd1, d); chk("R2 empty clear after write", d & 8'h20, 8'h00);
    rd(2'd1, d); chk("R2 empty set after hand-off", d & 8'h20, 8'h20);
    idle(40);
    rd(2'd0, d);
    wr(2'd1, 8'h40);

    // R5 back-to-back, only one transmit-done event
    glb_irq_en = 1'b1;
    wr(2'd2, 8'h58);
    r0 = txirq_rises;
    slv_pat = 8'h96;
    wr(2'd0, 8'h11);
    wr(2'd0, 8'h22);
    idle(80);
    chk("R5 one transmit-done event", 8'(txirq_rises - r0), 8'd1);
    chk("R5 slave saw last byte", slv_in, 8'h22);
    rd(2'd1, d); chk("R5 status after burst", d, 8'hE0);
    wr(2'd1, 8'h40); idle(2);
    chk("R8 tx irq drops after clear", {7'b0, irq_tx_done}, 8'h00);
    rd(2'd0, d); chk("R4 burst byte", d, 8'h96);
    glb_irq_en = 1'b0;

    // R7 flush and discard
    wr(2'd2, 8'h18);
    xfer(8'h77, 8'h55);
    wr(2'd2, 8'h08); idle(1);
    rd(2'd1, d); chk("R7 flush clears rx flag", d & 8'h80, 8'h00);
    xfer(8'h66, 8'hAA);
    wr(2'd2, 8'h18); idle(1);
    rd(2'd1, d); chk("R7 discarded frame leaves flag low", d & 8'h80, 8'h00);
    rd(2'd0, d); chk("R7 buffer flushed", d, 8'h00);

    // R8 receive and empty interrupts
    xfer(8'h01, 8'h42);
    wr(2'd2, 8'h98); idle(3);
    chk("R8 rx irq blocked by global enable", {7'b0, irq_rx_done}, 8'h00);
    glb_irq_en = 1'b1; idle(3);
    chk("R8 rx irq raised", {7'b0, irq_rx_done}, 8'h01);
    rd(2'd0, d); idle(2);
    chk("R8 rx irq drops after read", {7'b0, irq_rx_done}, 8'h00);
    wr(2'd2, 8'h38); idle(3);
    chk("R8 empty irq raised", {7'b0, irq_tx_empty}, 8'h01);
    glb_irq_en = 1'b0; idle(3);
    chk("R8 empty irq blocked", {7'b0, irq_tx_empty}, 8'h00);

    report();
    $finish;
  end
endmodule